// File: doc/BRIEF.md
# Active-Mode Clock Speed Switch Controller

This block sets the rate of the system clock for a small processor core. Both active rates come from one oscillator input. The system clock leaves the block as a one-cycle enable, `sys_clk_en`, in the oscillator domain. In high-speed mode the enable fires once every `HI_DIV` oscillator cycles. In medium-speed mode it fires once every `MED_DIV` oscillator cycles.

The core raises `sleep_req` when it executes a sleep instruction. The block samples the request on a system clock edge, that is, an oscillator edge at which `sys_clk_en` is high. At that point it decodes the standby, low-speed, medium-speed and direct-transfer control bits. A direct-transfer request moves the core between the two active speeds without stopping the clock.

A transfer has three phases. First come `PRE_STATES` system states, which cover the sleep instruction and internal processing, timed at the old rate. The divider ratio is then swapped at that system clock boundary. Finally come `POST_STATES` states of interrupt exception handling, timed at the new rate. A one-cycle `xfer_done` pulse closes the transfer. Any request that does not select a direct transfer produces a one-cycle `other_mode_req` flag and leaves the speed unchanged.

The controller has three states, with these transitions:
- `ST_IDLE` goes to `ST_PRE` when a direct request is accepted. It stays in `ST_IDLE` and pulses `other_mode_req` for any other request.
- `ST_PRE` goes to `ST_POST` at the boundary state, where the speed register is updated.
- `ST_POST` goes back to `ST_IDLE` on the last state, together with `xfer_done`.

Top module: `clkspeed_switch`

## Requirements
- R1: After reset the block is in high-speed mode (`speed_med`=0), with `xfer_done`=0 and `other_mode_req`=0. The first `sys_clk_en` pulse comes `HI_DIV`-1 oscillator cycles after reset is released.
- R2: In high-speed mode `sys_clk_en` is high for exactly one oscillator cycle in every `HI_DIV` (default 2).
- R3: In medium-speed mode `sys_clk_en` is high for exactly one oscillator cycle in every `MED_DIV` (default 16).
- R4: A request with standby=0, low-speed=0, medium-speed=1 and direct=1, accepted in high-speed mode, ends in medium-speed mode. `xfer_done` is seen 3×2 + 14×16 = 230 oscillator cycles after the accepting edge.
- R5: A request with standby=0, low-speed=0, medium-speed=0 and direct=1, accepted in medium-speed mode, ends in high-speed mode. `xfer_done` is seen 3×16 + 14×2 = 76 oscillator cycles after the accepting edge.
- R6: During a transfer, `speed_med` changes exactly `PRE_STATES` old-rate system clock periods after the accepting edge: 6 cycles going up to medium, 48 cycles going down to high.
- R7: `xfer_done` is high for exactly one oscillator cycle per transfer.
- R8: A request with direct=0, standby=1 or low-speed=1 raises `other_mode_req` for one cycle. It produces no speed change and no `xfer_done`.
- R9: A direct request for the speed already in effect completes with `xfer_done` after 17 periods of the current rate: 34 cycles at high speed, 272 at medium. The speed does not change.
- R10: `sleep_req` has no effect from the accepting edge until `xfer_done` has been issued. The transfer time and the final speed are unchanged.
- R11: The divider ratio changes only at a system clock boundary, so two `sys_clk_en` pulses are never closer than `HI_DIV` oscillator cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | Sleep instruction strobe, sampled when `sys_clk_en` is high |
| ctl_standby | input | 1 | Standby request bit |
| ctl_lowspd | input | 1 | Low-speed (subclock) request bit |
| ctl_medspd | input | 1 | Target speed select: 1 medium, 0 high |
| ctl_direct | input | 1 | Direct transfer enable |
| sys_clk_en | output | 1 | System clock enable, one oscillator cycle wide |
| speed_med | output | 1 | Current mode: 1 medium speed, 0 high speed |
| xfer_done | output | 1 | One-cycle pulse at the end of the post-switch states |
| other_mode_req | output | 1 | One-cycle flag: a non-direct mode was requested |

## Verification
The bench uses the default parameters: divide ratios of 2 and 16, with 3 pre-switch states and 14 post-switch states. These are small enough that every transfer can be timed cycle by cycle against totals the bench computes itself (230, 76, 34 and 272 cycles). The bench sweeps every combination of target speed and starting speed, and each of the three ways a request can fail to be direct. It also injects sleep strobes mid-transfer, early and late in the transfer, to show they are ignored.

// File: rtl/clkspeed_pkg.sv
package clkspeed_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_POST = 2'd2
    } xfer_state_t;

    typedef enum logic {
        SPD_HIGH = 1'b0,
        SPD_MED  = 1'b1
    } speed_t;
endpackage

// File: rtl/clkspeed_divider.sv
module clkspeed_divider
    import clkspeed_pkg::*;
#(
    parameter int HI_DIV  = 2,
    parameter int MED_DIV = 16
) (
    input  logic   clk_osc,
    input  logic   rst_n,
    input  speed_t speed,
    output logic   tick
);
    localparam int MAXDIV = (MED_DIV > HI_DIV) ? MED_DIV : HI_DIV;
    localparam int CW     = (MAXDIV > 2) ? $clog2(MAXDIV) : 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;

    // Terminal count follows the speed register, which only changes
    // on a tick edge, when the count wraps to zero anyway.
    always_comb begin
        if (speed == SPD_MED) limit = CW'(MED_DIV - 1);
        else                  limit = CW'(HI_DIV - 1);
    end

    assign tick = (cnt_q >= limit);

    always_ff @(posedge clk_osc or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/clkspeed_decode.sv
module clkspeed_decode
    import clkspeed_pkg::*;
(
    input  logic   standby,
    input  logic   lowspd,
    input  logic   medspd,
    input  logic   direct,
    output logic   is_direct,
    output speed_t target
);
    always_comb begin
        is_direct = direct && !standby && !lowspd;
        target    = medspd ? SPD_MED : SPD_HIGH;
    end
endmodule

// File: rtl/clkspeed_fsm.sv
module clkspeed_fsm
    import clkspeed_pkg::*;
#(
    parameter int PRE_STATES  = 3,
    parameter int POST_STATES = 14
) (
    input  logic   clk_osc,
    input  logic   rst_n,
    input  logic   tick,
    input  logic   sleep_req,
    input  logic   is_direct,
    input  speed_t target,
    output speed_t speed,
    output logic   done,
    output logic   other
);
    localparam int MAXST = (POST_STATES > PRE_STATES) ? POST_STATES : PRE_STATES;
    localparam int SW    = (MAXST > 2) ? $clog2(MAXST) : 1;

    xfer_state_t   state_q, state_d;
    logic [SW-1:0] scnt_q, scnt_d;
    speed_t        tgt_q, tgt_d;
    speed_t        spd_q, spd_d;
    logic          done_d, other_d;
    logic          done_q, other_q;

    // State register process.
    always_ff @(posedge clk_osc or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            scnt_q  <= '0;
            tgt_q   <= SPD_HIGH;
            spd_q   <= SPD_HIGH;
            done_q  <= 1'b0;
            other_q <= 1'b0;
        end else begin
            state_q <= state_d;
            scnt_q  <= scnt_d;
            tgt_q   <= tgt_d;
            spd_q   <= spd_d;
            done_q  <= done_d;
            other_q <= other_d;
        end
    end

    // Next-state and output process.
    always_comb begin
        state_d = state_q;
        scnt_d  = scnt_q;
        tgt_d   = tgt_q;
        spd_d   = spd_q;
        done_d  = 1'b0;
        other_d = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (tick && sleep_req) begin
                    if (is_direct) begin
                        state_d = ST_PRE;
                        scnt_d  = '0;
                        tgt_d   = target;
                    end else begin
                        other_d = 1'b1;
                    end
                end
            end
            ST_PRE: begin
                if (tick) begin
                    if (scnt_q == SW'(PRE_STATES - 1)) begin
                        state_d = ST_POST;
                        scnt_d  = '0;
                        spd_d   = tgt_q;
                    end else begin
                        scnt_d  = scnt_q + 1'b1;
                    end
                end
            end
            ST_POST: begin
                if (tick) begin
                    if (scnt_q == SW'(POST_STATES - 1)) begin
                        state_d = ST_IDLE;
                        scnt_d  = '0;
                        done_d  = 1'b1;
                    end else begin
                        scnt_d  = scnt_q + 1'b1;
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
                scnt_d  = '0;
            end
        endcase
    end

    assign speed = spd_q;
    assign done  = done_q;
    assign other = other_q;
endmodule

// File: rtl/clkspeed_switch.sv
module clkspeed_switch
    import clkspeed_pkg::*;
#(
    parameter int HI_DIV      = 2,
    parameter int MED_DIV     = 16,
    parameter int PRE_STATES  = 3,
    parameter int POST_STATES = 14
) (
    input  logic clk_osc,
    input  logic rst_n,
    input  logic sleep_req,
    input  logic ctl_standby,
    input  logic ctl_lowspd,
    input  logic ctl_medspd,
    input  logic ctl_direct,
    output logic sys_clk_en,
    output logic speed_med,
    output logic xfer_done,
    output logic other_mode_req
);
    speed_t speed;
    speed_t target;
    logic   is_direct;
    logic   tick;

    clkspeed_divider #(
        .HI_DIV  (HI_DIV),
        .MED_DIV (MED_DIV)
    ) u_div (
        .clk_osc (clk_osc),
        .rst_n   (rst_n),
        .speed   (speed),
        .tick    (tick)
    );

    clkspeed_decode u_dec (
        .standby   (ctl_standby),
        .lowspd    (ctl_lowspd),
        .medspd    (ctl_medspd),
        .direct    (ctl_direct),
        .is_direct (is_direct),
        .target    (target)
    );

    clkspeed_fsm #(
        .PRE_STATES  (PRE_STATES),
        .POST_STATES (POST_STATES)
    ) u_fsm (
        .clk_osc   (clk_osc),
        .rst_n     (rst_n),
        .tick      (tick),
        .sleep_req (sleep_req),
        .is_direct (is_direct),
        .target    (target),
        .speed     (speed),
        .done      (xfer_done),
        .other     (other_mode_req)
    );

    assign sys_clk_en = tick;
    assign speed_med  = (speed == SPD_MED);
endmodule

// File: rtl/clkspeed_switch_chk.sv
module clkspeed_switch_chk #(
    parameter int HI_DIV = 2
) (
    input logic clk_osc,
    input logic rst_n,
    input logic sys_clk_en,
    input logic speed_med,
    input logic xfer_done,
    input logic other_mode_req
);
    logic [7:0] gap_q;

    always_ff @(posedge clk_osc or negedge rst_n) begin
        if (!rst_n)          gap_q <= 8'd0;
        else if (sys_clk_en) gap_q <= 8'd0;
        else if (gap_q != 8'hFF) gap_q <= gap_q + 8'd1;
    end

    assert_done_single_R7: assert property (@(posedge clk_osc) disable iff (!rst_n)
        xfer_done |=> !xfer_done);

    assert_other_single_R8: assert property (@(posedge clk_osc) disable iff (!rst_n)
        other_mode_req |=> !other_mode_req);

    assert_done_xor_other_R8: assert property (@(posedge clk_osc) disable iff (!rst_n)
        !(xfer_done && other_mode_req));

    assert_speed_on_boundary_R11: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (speed_med != $past(speed_med)) |-> $past(sys_clk_en));

    assert_min_gap_R11: assert property (@(posedge clk_osc) disable iff (!rst_n)
        sys_clk_en |-> (32'(gap_q) >= HI_DIV - 1));
endmodule

bind clkspeed_switch clkspeed_switch_chk #(.HI_DIV(HI_DIV)) u_chk (
    .clk_osc        (clk_osc),
    .rst_n          (rst_n),
    .sys_clk_en     (sys_clk_en),
    .speed_med      (speed_med),
    .xfer_done      (xfer_done),
    .other_mode_req (other_mode_req)
);

// File: tb/clkspeed_switch_test.sv
`timescale 1ns/1ps
module clkspeed_switch_test;
    localparam int HI  = 2;
    localparam int MED = 16;
    localparam int PRE = 3;
    localparam int PST = 14;

    logic clk_osc = 1'b0;
    logic rst_n   = 1'b0;
    logic sleep_req = 1'b0;
    logic ctl_standby = 1'b0, ctl_lowspd = 1'b0, ctl_medspd = 1'b0, ctl_direct = 1'b0;
    logic sys_clk_en, speed_med, xfer_done, other_mode_req;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk_osc = ~clk_osc;

    clkspeed_switch #(.HI_DIV(HI), .MED_DIV(MED), .PRE_STATES(PRE), .POST_STATES(PST)) uut (
        .clk_osc(clk_osc), .rst_n(rst_n), .sleep_req(sleep_req),
        .ctl_standby(ctl_standby), .ctl_lowspd(ctl_lowspd),
        .ctl_medspd(ctl_medspd), .ctl_direct(ctl_direct),
        .sys_clk_en(sys_clk_en), .speed_med(speed_med),
        .xfer_done(xfer_done), .other_mode_req(other_mode_req)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Measure several enable intervals and compare with the expected period.
    task automatic measure_period(input string req, input int exp);
        int t;
        while (!sys_clk_en) @(negedge clk_osc);
        for (int k = 0; k < 6; k++) begin
            t = 0;
            do begin
                @(negedge clk_osc);
                t++;
            end while (!sys_clk_en && t < 100);
            check(req, t, exp);
        end
    endtask

    // Issue one sleep request and time it; optionally inject further strobes.
    task automatic run_sleep(input logic sb, input logic lo, input logic me, input logic dt,
                             input int inj, input int limit,
                             output int done_at, output int sw_at,
                             output int other_seen, output int done_cnt,
                             output int start_spd);
        int t;
        @(negedge clk_osc);
        while (!sys_clk_en) @(negedge clk_osc);
        start_spd = int'(speed_med);
        ctl_standby = sb; ctl_lowspd = lo; ctl_medspd = me; ctl_direct = dt;
        sleep_req = 1'b1;
        @(negedge clk_osc);
        sleep_req = 1'b0;
        t = 0; done_at = -1; sw_at = -1; done_cnt = 0;
        other_seen = int'(other_mode_req);
        while (t < limit) begin
            if (inj >= 0 && t == inj) begin
                sleep_req = 1'b1;
                ctl_medspd = ~me; ctl_direct = 1'b1;
            end
            if (inj >= 0 && t == inj + 40) sleep_req = 1'b0;
            @(negedge clk_osc);
            t++;
            if (sw_at < 0 && int'(speed_med) != start_spd) sw_at = t;
            if (xfer_done) begin
                done_cnt++;
                if (done_at < 0) done_at = t;
            end
            if (done_at >= 0 && t >= done_at + 3) break;
        end
        sleep_req = 1'b0;
        ctl_direct = 1'b0;
    endtask

    initial begin
        #1_000_000;
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int da, sw, ot, dc, ss, t;
        repeat (3) @(negedge clk_osc);
        rst_n = 1'b1;
        // R1: reset state and first enable
        check("R1 speed", int'(speed_med), 0);
        check("R1 done", int'(xfer_done), 0);
        check("R1 other", int'(other_mode_req), 0);
        t = 0;
        while (!sys_clk_en && t < 50) begin @(negedge clk_osc); t++; end
        check("R1 first enable", t, HI - 1);

        measure_period("R2 high period", HI);

        // R8: three kinds of non-direct request
        run_sleep(1'b0, 1'b0, 1'b1, 1'b0, -1, 300, da, sw, ot, dc, ss);
        check("R8 other flag direct=0", ot, 1);
        check("R8 no done direct=0", dc, 0);
        check("R8 no switch direct=0", sw, -1);
        run_sleep(1'b1, 1'b0, 1'b1, 1'b1, -1, 300, da, sw, ot, dc, ss);
        check("R8 other flag standby", ot, 1);
        check("R8 no done standby", dc, 0);
        check("R8 no switch standby", sw, -1);
        run_sleep(1'b0, 1'b1, 1'b1, 1'b1, -1, 300, da, sw, ot, dc, ss);
        check("R8 other flag lowspd", ot, 1);
        check("R8 no done lowspd", dc, 0);
        check("R8 no switch lowspd", sw, -1);

        // R9: same speed at high
        run_sleep(1'b0, 1'b0, 1'b0, 1'b1, -1, 400, da, sw, ot, dc, ss);
        check("R9 high same time", da, (PRE + PST) * HI);
        check("R9 high no switch", sw, -1);
        check("R9 no other flag", ot, 0);

        // R4/R6/R7: high to medium
        run_sleep(1'b0, 1'b0, 1'b1, 1'b1, -1, 400, da, sw, ot, dc, ss);
        check("R4 start high", ss, 0);
        check("R4 high->med time", da, PRE * HI + PST * MED);
        check("R6 switch point up", sw, PRE * HI);
        check("R7 done width", dc, 1);
        check("R4 final medium", int'(speed_med), 1);

        measure_period("R3 medium period", MED);

        // R9: same speed at medium
        run_sleep(1'b0, 1'b0, 1'b1, 1'b1, -1, 400, da, sw, ot, dc, ss);
        check("R9 med same time", da, (PRE + PST) * MED);
        check("R9 med no switch", sw, -1);

        // R5/R6/R7: medium to high
        run_sleep(1'b0, 1'b0, 1'b0, 1'b1, -1, 400, da, sw, ot, dc, ss);
        check("R5 start medium", ss, 1);
        check("R5 med->high time", da, PRE * MED + PST * HI);
        check("R6 switch point down", sw, PRE * MED);
        check("R7 done width down", dc, 1);
        check("R5 final high", int'(speed_med), 0);

        measure_period("R2 high period again", HI);

        // R10: strobes during transfers
        run_sleep(1'b0, 1'b0, 1'b1, 1'b1, 2, 400, da, sw, ot, dc, ss);
        check("R10 up time with strobe", da, PRE * HI + PST * MED);
        check("R10 up final", int'(speed_med), 1);
        check("R10 up single done", dc, 1);
        run_sleep(1'b0, 1'b0, 1'b0, 1'b1, 20, 400, da, sw, ot, dc, ss);
        check("R10 down time with strobe", da, PRE * MED + PST * HI);
        check("R10 down final", int'(speed_med), 0);
        check("R10 down single done", dc, 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule